// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers eight level-sensitive interrupt request lines from neighbouring peripherals and presents them to a host as one interrupt output. Each request line feeds one bit of a status byte. Line 0 serves the NAND flash controller and line 1 the MMC controller. Line 2 serves the USB host, line 3 the serial port and line 4 the frame buffer. Lines 5 to 7 are spare.

A status bit is not sticky. It is the level of its line, captured on each clock. A mask byte selects which status bits may raise the host interrupt. A routing byte is kept as plain read/write storage. The block does not use it. A fixed revision byte identifies the block. Software reaches all of this through a byte-wide register port. Writes take effect on the clock edge. Read data appears one cycle after the read strobe.

The host interrupt is registered. It is asserted one cycle after the status or mask registers hold at least one common set bit. A change on a request line therefore reaches the output two clock edges later.

Top module: `irq_gather`

## Requirements
- R1: While reset is high and in the first cycle after it, irq_out is 0 and rdata is 0. Status, mask and routing all read back as 0x00 after reset, as long as the request lines are low.
- R2: A read of offset 0x50 returns the request lines as sampled on the clock edge before the read strobe. Bit i is line i. A bit that was set reads 0 once its line goes low.
- R3: A write to offset 0x52 loads the mask byte. A read of 0x52 returns that value.
- R4: A write to offset 0x54 loads the routing byte. A read of 0x54 returns it. The routing value never changes irq_out.
- R5: irq_out is 1 exactly when status AND mask, as held in the previous cycle, is nonzero. A request line change is therefore seen on irq_out after two clock edges. A mask write is seen after one further edge.
- R6: A read of offset 0x08 returns the REV_ID parameter (default 0x3A). Writes to 0x08 are ignored.
- R7: A read of any offset other than 0x08, 0x50, 0x52 or 0x54 returns 0x00. A write to such an offset leaves mask, routing and irq_out unchanged.
- R8: Status is read-only. A write to 0x50 leaves the value read from 0x50 unchanged.
- R9: rdata carries a read result for exactly the one cycle after a cycle with rd_en high. In any other cycle it is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC (8) | Level-sensitive interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Register byte offset |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, registered |
| irq_out | output | 1 | Host interrupt, registered |

## Verification
The assertions assume that the request lines, strobes, address and write data are synchronous to clk and settle before each rising edge. They also assume that wr_en and rd_en may both be high in one cycle without any ordering between them. The bench changes every input only on the falling edge, one half period away from the capture edge. It never relies on a read and a write to the same offset in one cycle. Request lines are held for at least two cycles before the interrupt output is sampled, so the two-edge latency is always observed.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned DEF_SRC    = 8;
  localparam int unsigned DEF_AW     = 8;
  localparam int unsigned DEF_DW     = 8;
  localparam logic [7:0]  DEF_REV    = 8'h3A;
  localparam logic [7:0]  OFF_REV    = 8'h08;
  localparam logic [7:0]  OFF_STATUS = 8'h50;
  localparam logic [7:0]  OFF_MASK   = 8'h52;
  localparam logic [7:0]  OFF_ROUTE  = 8'h54;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REV,
    SEL_STATUS,
    SEL_MASK,
    SEL_ROUTE
  } reg_sel_e;
endpackage

// File: rtl/irq_level_capture.sv
module irq_level_capture #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  output logic [NUM_SRC-1:0] status_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= src_lvl[i];
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h52,
  parameter logic [ADDR_W-1:0] ROUTE_OFF = 8'h54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] route_q
);
  logic hit_mask, hit_route;
  assign hit_mask  = wr_en && (addr == MASK_OFF);
  assign hit_route = wr_en && (addr == ROUTE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (hit_mask)  mask_q  <= wdata;
      if (hit_route) route_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_gather_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [DATA_W-1:0] REV_ID     = 8'h3A,
  parameter logic [ADDR_W-1:0] REV_OFF    = 8'h08,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFF   = 8'h52,
  parameter logic [ADDR_W-1:0] ROUTE_OFF  = 8'h54
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] status,
  input  logic [DATA_W-1:0]  mask,
  input  logic [DATA_W-1:0]  route,
  output logic [DATA_W-1:0]  rdata
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] status_ext;
  logic [DATA_W-1:0] mux_val;

  always_comb begin
    status_ext = '0;
    status_ext[NUM_SRC-1:0] = status;
  end

  always_comb begin
    if      (addr == REV_OFF)    sel = SEL_REV;
    else if (addr == STATUS_OFF) sel = SEL_STATUS;
    else if (addr == MASK_OFF)   sel = SEL_MASK;
    else if (addr == ROUTE_OFF)  sel = SEL_ROUTE;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_REV:    mux_val = REV_ID;
      SEL_STATUS: mux_val = status_ext;
      SEL_MASK:   mux_val = mask;
      SEL_ROUTE:  mux_val = route;
      default:    mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mux_val;
    else            rdata <= '0;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status,
  input  logic [DATA_W-1:0]  mask,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] live;
  assign live = status & mask[NUM_SRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |live;
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_SRC,
  parameter int unsigned ADDR_W  = DEF_AW,
  parameter int unsigned DATA_W  = DEF_DW,
  parameter logic [DATA_W-1:0] REV_ID     = DEF_REV,
  parameter logic [ADDR_W-1:0] REV_OFF    = OFF_REV,
  parameter logic [ADDR_W-1:0] STATUS_OFF = OFF_STATUS,
  parameter logic [ADDR_W-1:0] MASK_OFF   = OFF_MASK,
  parameter logic [ADDR_W-1:0] ROUTE_OFF  = OFF_ROUTE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] status_q;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  route_q;

  irq_level_capture #(.NUM_SRC(NUM_SRC)) u_capture (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .status_q(status_q)
  );

  irq_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_OFF(MASK_OFF), .ROUTE_OFF(ROUTE_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mask_q(mask_q), .route_q(route_q)
  );

  irq_read_port #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV_ID(REV_ID),
    .REV_OFF(REV_OFF), .STATUS_OFF(STATUS_OFF),
    .MASK_OFF(MASK_OFF), .ROUTE_OFF(ROUTE_OFF)
  ) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .status(status_q),
    .mask(mask_q), .route(route_q), .rdata(rdata)
  );

  irq_merge #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst(rst), .status(status_q), .mask(mask_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h52
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] status,
  input logic [DATA_W-1:0]  mask
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == 1'b0 && rdata == '0));

  assert_status_level_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status == $past(src_lvl)));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MASK_OFF) |=> (mask == $past(wdata)));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == MASK_OFF) |=> $stable(mask));

  assert_irq_merge_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == |($past(status) & $past(mask[NUM_SRC-1:0]))));

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

bind irq_gather irq_gather_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk(clk), .rst(rst), .src_lvl(src_lvl), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
  .status(status_q), .mask(mask_q)
);

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_lvl = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  irq_gather u_irq_gather (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [7:0] v);
    @(negedge clk);
    src_lvl = v;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: note read strobes at the edge, compare one half period later
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read data", rdata, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    wait_n(3);
    check("R1 irq_out in reset", {7'd0, irq_out}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);
    rd(8'h50, 8'h00, "R1 status reset");
    rd(8'h52, 8'h00, "R1 mask reset");
    rd(8'h54, 8'h00, "R1 route reset");

    rd(8'h08, 8'h3A, "R6 revision");
    wr(8'h08, 8'hFF);
    rd(8'h08, 8'h3A, "R6 revision after write");

    set_src(8'hA5);
    wait_n(1);
    rd(8'h50, 8'hA5, "R2 status A5");
    set_src(8'h5A);
    wait_n(1);
    rd(8'h50, 8'h5A, "R2 status follows down");
    check("R5 mask zero keeps irq low", {7'd0, irq_out}, 8'h00);

    wr(8'h52, 8'h01);
    wait_n(1);
    check("R5 no overlap", {7'd0, irq_out}, 8'h00);
    wr(8'h52, 8'h02);
    @(negedge clk);
    check("R5 overlap raises irq", {7'd0, irq_out}, 8'h01);
    rd(8'h52, 8'h02, "R3 mask readback");

    set_src(8'h58);
    @(negedge clk);
    check("R5 irq still high one edge after drop", {7'd0, irq_out}, 8'h01);
    @(negedge clk);
    check("R5 irq low two edges after drop", {7'd0, irq_out}, 8'h00);

    wr(8'h54, 8'hC3);
    rd(8'h54, 8'hC3, "R4 route readback");
    wr(8'h54, 8'hFF);
    wait_n(2);
    check("R4 route does not raise irq", {7'd0, irq_out}, 8'h00);
    wr(8'h54, 8'hC3);

    wr(8'h50, 8'hFF);
    rd(8'h50, 8'h58, "R8 status read-only");

    wr(8'h51, 8'hFF);
    wr(8'h53, 8'hFF);
    wr(8'h55, 8'hFF);
    wait_n(2);
    check("R7 unmapped write leaves irq", {7'd0, irq_out}, 8'h00);
    rd(8'h52, 8'h02, "R7 mask unchanged");
    rd(8'h54, 8'hC3, "R7 route unchanged");
    rd(8'h51, 8'h00, "R7 unmapped read 51");
    rd(8'hFF, 8'h00, "R7 unmapped read FF");

    wr(8'h52, 8'hFF);
    set_src(8'h80);
    wait_n(2);
    check("R5 line 7 with full mask", {7'd0, irq_out}, 8'h01);

    rd(8'h08, 8'h3A, "R9 read result");
    @(negedge clk);
    check("R9 rdata returns to zero", rdata, 8'h00);

    wait_n(2);
    if (exp_q.size() != 0) check("R9 reads outstanding", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule